// File: doc/BRIEF.md
# Watchpoint Exception Deferral Unit

This unit watches the instruction-fetch address and the data-access address of a core. It compares each one with a programmable watch address and raises a watch exception request when they match. The comparison ignores the low three address bits, so the watch covers one aligned doubleword. Each access type has its own enable: fetch, load and store.

The core supplies three mode flags: exception level, error level and debug mode. A match is taken at once only when all three flags are clear. If any flag is set, the match is not dropped. It is recorded in a sticky pending bit. That bit by itself retriggers the exception on every cycle in which all three flags are clear, and it stays set until software writes a zero to it. Software cannot set it.

Each request carries the watch cause code (23), the general exception vector offset (0x180) and a one-hot code for the access type that triggered it. The outputs are registered, so a request appears one cycle after the cycle whose inputs caused it.

Top module: `watch_defer_unit`

## Requirements
- R1: A fetch match with all three flags clear gives, on the next cycle, `exc_req`=1, `exc_cause`=23, `exc_vec`=0x180 and `exc_src`=2'b01 (bit 0 means fetch, bit 1 means data).
- R2: A match compares address bits 31:3 only. An address that differs from the watch address only in bits 2:0 matches. An address that differs in bit 3 or above does not match.
- R3: A fetch matches only when the fetch enable is 1. A data access matches only when the store enable is 1 (for `data_is_store`=1) or the load enable is 1 (for a load). A data match reports `exc_src`=2'b10.
- R4: A match in a cycle where any of `flag_exl`, `flag_erl` or `flag_dbg` is 1 gives no request on the next cycle and sets `watch_pend` on the next cycle.
- R5: In every cycle where `watch_pend` is 1 and all three flags are 0, a request follows on the next cycle with no address match needed. It reports the source of the most recent blocked match, unless a new match occurs in that same cycle; a new match reports its own source.
- R6: `watch_pend` stays set through taken exceptions. It clears only through a write with `pend_we`=1 and `pend_wdata`=0. A write with `pend_wdata`=1 never sets it. A blocked match in the same cycle as a clearing write leaves the bit set.
- R7: When a fetch and a data access match in the same cycle, the request reports `exc_src`=2'b01.
- R8: Reset clears `watch_pend` and all three enables, so no access matches after reset until the configuration is written.
- R9: In a cycle with `exc_req`=0, `exc_cause`, `exc_vec` and `exc_src` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Writes the watch address and the three enables |
| cfg_addr | input | 32 | New watch address (bits 31:3 are kept) |
| cfg_en_fetch | input | 1 | New enable for fetch matches |
| cfg_en_load | input | 1 | New enable for load matches |
| cfg_en_store | input | 1 | New enable for store matches |
| pend_we | input | 1 | Write strobe for the pending bit |
| pend_wdata | input | 1 | Pending write value (only 0 has an effect) |
| fetch_vld | input | 1 | Instruction fetch valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| data_vld | input | 1 | Data access valid this cycle |
| data_is_store | input | 1 | 1 for a store, 0 for a load |
| data_addr | input | 32 | Data access address |
| flag_exl | input | 1 | Exception-level flag |
| flag_erl | input | 1 | Error-level flag |
| flag_dbg | input | 1 | Debug-mode flag |
| exc_req | output | 1 | Watch exception request |
| exc_cause | output | 5 | Cause code, 23 during a request |
| exc_vec | output | 12 | Vector offset, 0x180 during a request |
| exc_src | output | 2 | One-hot trigger source: bit 0 fetch, bit 1 data |
| watch_pend | output | 1 | Sticky deferred-watch bit |

## Verification
The bench targets the following corner cases:
- **Granularity boundary.** It uses addresses that differ from the watch address only in bits 2:0, and addresses that differ only in bit 3. A design that compares too many or too few bits would miss the first kind or fire on the second.
- **Same-cycle races.** It drives a fetch match and a data match in one cycle, and a blocked match in the same cycle as a clearing write. Wrong priority shows up as the data code on `exc_src`. A wrong set-versus-clear order shows up as a lost pending bit.
- **Deferred exceptions.** It drops all three flags while the pending bit is set and there is no address activity. A design that ties the exception to a live match never fires there. A design that clears the bit by itself, or honours a write of 1, shows a wrong `watch_pend`.
- **Random traffic.** Random traffic with frequent near-miss addresses compares every output in every cycle against a model in the bench.

// File: rtl/watch_pkg.sv
package watch_pkg;
   localparam int SRC_W = 2;
   typedef enum logic [SRC_W-1:0] {
      SRC_NONE  = 2'b00,
      SRC_FETCH = 2'b01,
      SRC_DATA  = 2'b10
   } wsrc_t;
endpackage

// File: rtl/watch_cfg.sv
module watch_cfg #(
   parameter int ADDR_W = 32,
   parameter int GRAN   = 3,
   localparam int TAG_W = ADDR_W - GRAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_en_f,
   input  logic              wr_en_l,
   input  logic              wr_en_s,
   output logic [TAG_W-1:0]  tag_q,
   output logic              en_f_q,
   output logic              en_l_q,
   output logic              en_s_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= '0;
         en_f_q <= 1'b0;
         en_l_q <= 1'b0;
         en_s_q <= 1'b0;
      end else if (we) begin
         tag_q  <= wr_addr[ADDR_W-1:GRAN];
         en_f_q <= wr_en_f;
         en_l_q <= wr_en_l;
         en_s_q <= wr_en_s;
      end
   end
endmodule

// File: rtl/watch_cmp.sv
module watch_cmp #(
   parameter int ADDR_W = 32,
   parameter int GRAN   = 3,
   localparam int TAG_W = ADDR_W - GRAN
) (
   input  logic              vld,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);
   generate
      if (GRAN == 0) begin : g_exact
         assign hit = vld & en & (addr == tag);
      end else begin : g_masked
         logic [GRAN-1:0] unused_low;
         assign unused_low = addr[GRAN-1:0];
         assign hit = vld & en & (addr[ADDR_W-1:GRAN] == tag);
      end
   endgenerate
endmodule

// File: rtl/watch_pend.sv
module watch_pend
   import watch_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  blocked,
   input  logic  new_hit,
   input  wsrc_t new_src,
   input  logic  clr_we,
   input  logic  clr_wdata,
   output logic  pend_q,
   output wsrc_t psrc_q
);
   logic do_clr;
   assign do_clr = clr_we & ~clr_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         psrc_q <= SRC_NONE;
      end else if (blocked && new_hit) begin
         pend_q <= 1'b1;
         psrc_q <= new_src;
      end else if (do_clr) begin
         pend_q <= 1'b0;
         psrc_q <= SRC_NONE;
      end
   end
endmodule

// File: rtl/watch_resp.sv
module watch_resp
   import watch_pkg::*;
#(
   parameter int CAUSE_W    = 5,
   parameter int VEC_W      = 12,
   parameter int WATCH_CODE = 23,
   parameter int VEC_OFF    = 'h180
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  wsrc_t              src,
   output logic               req_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [VEC_W-1:0]   vec_q,
   output logic [SRC_W-1:0]   src_q
);
   localparam logic [CAUSE_W-1:0] CODE_V = CAUSE_W'(WATCH_CODE);
   localparam logic [VEC_W-1:0]   VEC_V  = VEC_W'(VEC_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         cause_q <= '0;
         vec_q   <= '0;
         src_q   <= '0;
      end else begin
         req_q   <= fire;
         cause_q <= fire ? CODE_V : '0;
         vec_q   <= fire ? VEC_V : '0;
         src_q   <= fire ? src : '0;
      end
   end
endmodule

// File: rtl/watch_defer_unit.sv
module watch_defer_unit
   import watch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int GRAN       = 3,
   parameter int CAUSE_W    = 5,
   parameter int VEC_W      = 12,
   parameter int WATCH_CODE = 23,
   parameter int VEC_OFF    = 'h180
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic               cfg_en_fetch,
   input  logic               cfg_en_load,
   input  logic               cfg_en_store,
   input  logic               pend_we,
   input  logic               pend_wdata,
   input  logic               fetch_vld,
   input  logic [ADDR_W-1:0]  fetch_addr,
   input  logic               data_vld,
   input  logic               data_is_store,
   input  logic [ADDR_W-1:0]  data_addr,
   input  logic               flag_exl,
   input  logic               flag_erl,
   input  logic               flag_dbg,
   output logic               exc_req,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic [VEC_W-1:0]   exc_vec,
   output logic [SRC_W-1:0]   exc_src,
   output logic               watch_pend
);
   localparam int TAG_W = ADDR_W - GRAN;

   generate
      if (GRAN < 0 || GRAN >= ADDR_W) begin : g_bad_gran
         $error("GRAN must lie in 0..ADDR_W-1");
      end
      if (WATCH_CODE < 0 || WATCH_CODE >= (1 << CAUSE_W)) begin : g_bad_code
         $error("WATCH_CODE does not fit in CAUSE_W bits");
      end
      if (VEC_OFF < 0 || VEC_OFF >= (1 << VEC_W)) begin : g_bad_vec
         $error("VEC_OFF does not fit in VEC_W bits");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q;
   logic             en_f_q, en_l_q, en_s_q;
   logic             data_en;
   logic             fetch_hit, data_hit, any_hit, blocked, fire;
   logic             pend_q;
   wsrc_t            psrc_q, hit_src, fire_src;

   watch_cfg #(.ADDR_W(ADDR_W), .GRAN(GRAN)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_addr(cfg_addr),
      .wr_en_f(cfg_en_fetch), .wr_en_l(cfg_en_load), .wr_en_s(cfg_en_store),
      .tag_q(tag_q), .en_f_q(en_f_q), .en_l_q(en_l_q), .en_s_q(en_s_q)
   );

   assign data_en = data_is_store ? en_s_q : en_l_q;

   watch_cmp #(.ADDR_W(ADDR_W), .GRAN(GRAN)) cmp_fetch_i (
      .vld(fetch_vld), .en(en_f_q), .addr(fetch_addr), .tag(tag_q), .hit(fetch_hit)
   );
   watch_cmp #(.ADDR_W(ADDR_W), .GRAN(GRAN)) cmp_data_i (
      .vld(data_vld), .en(data_en), .addr(data_addr), .tag(tag_q), .hit(data_hit)
   );

   assign any_hit  = fetch_hit | data_hit;
   assign blocked  = flag_exl | flag_erl | flag_dbg;
   assign hit_src  = fetch_hit ? SRC_FETCH : SRC_DATA;
   assign fire     = ~blocked & (any_hit | pend_q);
   assign fire_src = any_hit ? hit_src : psrc_q;

   watch_pend pend_i (
      .clk(clk), .rst_n(rst_n), .blocked(blocked), .new_hit(any_hit),
      .new_src(hit_src), .clr_we(pend_we), .clr_wdata(pend_wdata),
      .pend_q(pend_q), .psrc_q(psrc_q)
   );

   watch_resp #(
      .CAUSE_W(CAUSE_W), .VEC_W(VEC_W), .WATCH_CODE(WATCH_CODE), .VEC_OFF(VEC_OFF)
   ) resp_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .src(fire_src),
      .req_q(exc_req), .cause_q(exc_cause), .vec_q(exc_vec), .src_q(exc_src)
   );

   assign watch_pend = pend_q;
endmodule

// File: rtl/watch_defer_unit_chk.sv
module watch_defer_unit_chk #(
   parameter int CAUSE_W    = 5,
   parameter int VEC_W      = 12,
   parameter int WATCH_CODE = 23,
   parameter int VEC_OFF    = 'h180
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flag_exl,
   input logic               flag_erl,
   input logic               flag_dbg,
   input logic               pend_we,
   input logic               pend_wdata,
   input logic               fetch_hit,
   input logic               data_hit,
   input logic               exc_req,
   input logic [CAUSE_W-1:0] exc_cause,
   input logic [VEC_W-1:0]   exc_vec,
   input logic [1:0]         exc_src,
   input logic               watch_pend
);
   logic blk;
   assign blk = flag_exl | flag_erl | flag_dbg;

   // R1
   req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> (exc_cause == CAUSE_W'(WATCH_CODE)) && (exc_vec == VEC_W'(VEC_OFF))
                  && ($countones(exc_src) == 1));

   // R4
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk |=> !exc_req);

   // R4
   blocked_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk && (fetch_hit || data_hit)) |=> watch_pend);

   // R5
   pend_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_pend && !blk) |=> exc_req);

   // R6
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_pend && !(pend_we && !pend_wdata)) |=> watch_pend);

   // R6
   pend_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!watch_pend && !(blk && (fetch_hit || data_hit))) |=> !watch_pend);

   // R7
   fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_hit && data_hit && !blk) |=> (exc_src == 2'b01));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> (exc_cause == '0) && (exc_vec == '0) && (exc_src == 2'b00));
endmodule

bind watch_defer_unit watch_defer_unit_chk #(
   .CAUSE_W(CAUSE_W), .VEC_W(VEC_W), .WATCH_CODE(WATCH_CODE), .VEC_OFF(VEC_OFF)
) chk_i (
   .clk(clk), .rst_n(rst_n), .flag_exl(flag_exl), .flag_erl(flag_erl),
   .flag_dbg(flag_dbg), .pend_we(pend_we), .pend_wdata(pend_wdata),
   .fetch_hit(fetch_hit), .data_hit(data_hit), .exc_req(exc_req),
   .exc_cause(exc_cause), .exc_vec(exc_vec), .exc_src(exc_src),
   .watch_pend(watch_pend)
);

// File: tb/watch_defer_unit_tb_top.sv
`timescale 1ns/1ps
module watch_defer_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_en_fetch = 0, cfg_en_load = 0, cfg_en_store = 0;
   logic [31:0] cfg_addr = '0;
   logic        pend_we = 0, pend_wdata = 0;
   logic        fetch_vld = 0, data_vld = 0, data_is_store = 0;
   logic [31:0] fetch_addr = '0, data_addr = '0;
   logic        flag_exl = 0, flag_erl = 0, flag_dbg = 0;
   logic        exc_req, watch_pend;
   logic [4:0]  exc_cause;
   logic [11:0] exc_vec;
   logic [1:0]  exc_src;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model state
   logic [31:0] m_base = '0;
   logic        m_ef = 0, m_el = 0, m_es = 0;
   logic        m_pend = 0;
   logic [1:0]  m_psrc = 2'b00;
   logic        e_req = 0;
   logic [1:0]  e_src = 2'b00;

   always #10 clk = ~clk;

   watch_defer_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_en_fetch(cfg_en_fetch), .cfg_en_load(cfg_en_load), .cfg_en_store(cfg_en_store),
      .pend_we(pend_we), .pend_wdata(pend_wdata), .fetch_vld(fetch_vld),
      .fetch_addr(fetch_addr), .data_vld(data_vld), .data_is_store(data_is_store),
      .data_addr(data_addr), .flag_exl(flag_exl), .flag_erl(flag_erl),
      .flag_dbg(flag_dbg), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_vec(exc_vec), .exc_src(exc_src), .watch_pend(watch_pend)
   );

   function automatic logic same_dw(input logic [31:0] a, input logic [31:0] b);
      return a[31:3] == b[31:3];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // One clock: model computes from the inputs now applied, then outputs compared.
   task automatic step(input string req);
      logic hf, hd, blk, pend_n;
      logic [1:0] hsrc, psrc_n;
      hf  = fetch_vld & m_ef & same_dw(fetch_addr, m_base);
      hd  = data_vld & (data_is_store ? m_es : m_el) & same_dw(data_addr, m_base);
      blk = flag_exl | flag_erl | flag_dbg;
      hsrc = hf ? 2'b01 : 2'b10;
      e_req = !blk && (hf || hd || m_pend);
      e_src = !e_req ? 2'b00 : ((hf || hd) ? hsrc : m_psrc);
      pend_n = m_pend; psrc_n = m_psrc;
      if (blk && (hf || hd)) begin pend_n = 1'b1; psrc_n = hsrc; end
      else if (pend_we && !pend_wdata) begin pend_n = 1'b0; psrc_n = 2'b00; end
      @(posedge clk);
      m_pend = pend_n; m_psrc = psrc_n;
      if (cfg_we) begin
         m_base = cfg_addr; m_ef = cfg_en_fetch; m_el = cfg_en_load; m_es = cfg_en_store;
      end
      @(negedge clk);
      check({req, " req"}, 32'(exc_req), 32'(e_req));
      check({req, " src"}, 32'(exc_src), 32'(e_src));
      check({req, " cause"}, 32'(exc_cause), e_req ? 32'd23 : 32'd0);
      check({req, " vec"}, 32'(exc_vec), e_req ? 32'h180 : 32'd0);
      check({req, " pend"}, 32'(watch_pend), 32'(m_pend));
   endtask

   task automatic idle();
      cfg_we = 0; pend_we = 0; fetch_vld = 0; data_vld = 0;
      flag_exl = 0; flag_erl = 0; flag_dbg = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 pend after reset", 32'(watch_pend), 0);
      check("R9 idle after reset", 32'(exc_req), 0);
      rst_n = 1;
      @(negedge clk);
      // R8: enables cleared, address 0 does not match
      fetch_vld = 1; fetch_addr = 32'h0; data_vld = 1; data_addr = 32'h4;
      step("R8");
      idle();
      // program watch at 0x1000_0A48, all enables
      cfg_we = 1; cfg_addr = 32'h1000_0A48; cfg_en_fetch = 1; cfg_en_load = 1; cfg_en_store = 1;
      step("R1");
      idle();
      // R1: fetch hit
      fetch_vld = 1; fetch_addr = 32'h1000_0A48;
      step("R1");
      // R2: low bits differ -> hit; bit 3 differs -> miss
      fetch_addr = 32'h1000_0A4F; step("R2");
      fetch_addr = 32'h1000_0A40; step("R2");
      fetch_addr = 32'h1000_0A50; step("R2");
      idle();
      // R3: data load/store with enables
      data_vld = 1; data_addr = 32'h1000_0A4A; data_is_store = 0; step("R3");
      cfg_we = 1; cfg_en_fetch = 0; cfg_en_load = 0; cfg_en_store = 1; step("R3");
      cfg_we = 0; data_is_store = 0; step("R3");
      data_is_store = 1; step("R3");
      idle(); fetch_vld = 1; fetch_addr = 32'h1000_0A48; step("R3");
      idle();
      cfg_we = 1; cfg_en_fetch = 1; cfg_en_load = 1; cfg_en_store = 1; step("R3");
      idle();
      // R7: both hit
      fetch_vld = 1; fetch_addr = 32'h1000_0A48; data_vld = 1; data_addr = 32'h1000_0A49;
      step("R7");
      idle();
      // R4: blocked data match
      flag_erl = 1; data_vld = 1; data_addr = 32'h1000_0A48; step("R4");
      data_vld = 0; flag_erl = 0; flag_dbg = 1; step("R4");
      // R5: deferred fire with no activity, repeats
      idle(); step("R5"); step("R5");
      // R6: write 1 ignored, clear with 0
      pend_we = 1; pend_wdata = 1; step("R6");
      pend_wdata = 0; step("R6");
      idle(); step("R6");
      pend_we = 1; pend_wdata = 1; step("R6");
      idle();
      // R6: blocked match same cycle as clear keeps pending
      flag_exl = 1; fetch_vld = 1; fetch_addr = 32'h1000_0A48; pend_we = 1; pend_wdata = 0;
      step("R6");
      idle(); step("R5");
      pend_we = 1; pend_wdata = 0; flag_dbg = 1; step("R6");
      idle();
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         cfg_we = ($urandom % 64) == 0;
         cfg_addr = ($urandom % 2) ? m_base ^ 32'(1 << ($urandom % 6)) : $urandom;
         cfg_en_fetch = $urandom % 4 != 0;
         cfg_en_load = $urandom % 4 != 0;
         cfg_en_store = $urandom % 4 != 0;
         pend_we = ($urandom % 8) == 0;
         pend_wdata = $urandom % 2;
         fetch_vld = $urandom % 2;
         fetch_addr = ($urandom % 3 == 0) ? {m_base[31:3], 3'($urandom)} : m_base ^ 32'(1 << ($urandom % 32));
         data_vld = $urandom % 2;
         data_is_store = $urandom % 2;
         data_addr = ($urandom % 3 == 0) ? {m_base[31:3], 3'($urandom)} : $urandom;
         flag_exl = ($urandom % 5) == 0;
         flag_erl = ($urandom % 7) == 0;
         flag_dbg = ($urandom % 9) == 0;
         step("R1/R5 random");
      end
      idle();
      step("R9");
      finish_run();
   end
endmodule